// File: doc/BRIEF.md
# Logical Channel Combiner

This block folds sixteen physical detector channels into eight logical output lines. Each physical channel first passes through a source selector. The selector takes either the live physical input or one bit of a 16-bit test pattern held in a configuration register. A per-channel disable mask then clears any bit whose mask bit is set. The masked vector goes to the combiner, which applies one of six fan-in rules chosen by a 3-bit mode code. The rules are plain OR over groups of two, four or eight neighbours, AND over neighbouring pairs, and OR over two or four paired coincidences.

The logical lines are combinational, so they can be forwarded in the same cycle. A registered copy is also provided for downstream logic that needs a clean clock-aligned version. Outputs that a coarse mode leaves without a group are held low.

Top module: `lch_combiner`

## Requirements
- R1: With `pat_sel` = 1 the combiner input is `pat_reg`, and `phys_in` has no effect. With `pat_sel` = 0 the combiner input is `phys_in`, and `pat_reg` has no effect.
- R2: A set bit `chan_mask[i]` forces combiner input bit i to 0, whichever source is selected.
- R3: Mode 0 (pair OR): `lch_out[k]` = c[2k] | c[2k+1] for k = 0..7, where c is the masked combiner input.
- R4: Mode 1 (quad OR): `lch_out[k]` = OR of c[4k]..c[4k+3] for k = 0..3. `lch_out[7:4]` = 0.
- R5: Mode 2 (octet OR): `lch_out[k]` = OR of c[8k]..c[8k+7] for k = 0..1. `lch_out[7:2]` = 0.
- R6: Mode 3 (pair AND): `lch_out[k]` = c[2k] & c[2k+1] for k = 0..7.
- R7: Mode 4 (OR of two coincidences): `lch_out[k]` = (c[4k]&c[4k+1]) | (c[4k+2]&c[4k+3]) for k = 0..3. `lch_out[7:4]` = 0.
- R8: Mode 5 (OR of four coincidences): `lch_out[k]` is the OR over j = 0..3 of (c[8k+2j] & c[8k+2j+1]) for k = 0..1. `lch_out[7:2]` = 0.
- R9: Mode codes 6 and 7 drive all eight logical outputs low.
- R10: `lch_out` follows its inputs within the same cycle. `lch_q` equals the `lch_out` value from the previous rising clock edge. `lch_q` is 0 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered copy |
| rst_n | input | 1 | Active-low asynchronous reset |
| phys_in | input | 16 | Physical channel inputs |
| chan_mask | input | 16 | Per-channel disable, 1 = forced to 0 |
| mode | input | 3 | Combination rule code |
| pat_sel | input | 1 | 1 = use pattern register as source |
| pat_reg | input | 16 | Internal test pattern |
| lch_out | output | 8 | Combinational logical channels |
| lch_q | output | 8 | Logical channels registered on clk |

## Verification
Every mode code, including the two spare codes, is driven with an all-zero vector, an all-one vector, a walking single bit and a walking adjacent pair. The walking single bit shows which input feeds which output group, and it separates the OR rules from the coincidence rules. The walking pair shows where one pair boundary ends and the next begins, so it separates the pair, quad and octet groupings. A long pseudo-random series then runs with random masks and with both source settings. In these vectors the unselected source carries the complement of the selected one, so a leak from the wrong source or an ignored mask bit flips an output. The registered copy is compared one edge later on every vector.

// File: rtl/lch_pkg.sv
package lch_pkg;
  typedef enum logic [2:0] {
    M_OR2   = 3'd0,
    M_OR4   = 3'd1,
    M_OR8   = 3'd2,
    M_AND2  = 3'd3,
    M_CP2   = 3'd4,
    M_CP4   = 3'd5,
    M_SPR6  = 3'd6,
    M_SPR7  = 3'd7
  } lch_mode_e;

  // masked source: choose pattern or live channel, then drop disabled bits
  function automatic logic [15:0] lch_source(input logic [15:0] live,
                                             input logic [15:0] pat,
                                             input logic        use_pat,
                                             input logic [15:0] dis);
    lch_source = (use_pat ? pat : live) & ~dis;
  endfunction

  // coincidence of one neighbouring pair
  function automatic logic pair_hit(input logic [1:0] p);
    pair_hit = p[0] & p[1];
  endfunction
endpackage

// File: rtl/lch_src_sel.sv
module lch_src_sel #(
  parameter int NPHYS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPHYS-1:0] phys_in,
  input  logic [NPHYS-1:0] pat_reg,
  input  logic             pat_sel,
  input  logic [NPHYS-1:0] chan_mask,
  output logic [NPHYS-1:0] comb_in
);
  logic [NPHYS-1:0] src_w;

  assign src_w   = pat_sel ? pat_reg : phys_in;
  assign comb_in = src_w & ~chan_mask;

  // disabled channels never reach the combiner
  assert_mask_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_in & chan_mask) == '0);
  // enabled channels follow the selected source
  assert_pattern_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pat_sel |-> ((comb_in ^ pat_reg) & ~chan_mask) == '0);
  assert_live_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pat_sel |-> ((comb_in ^ phys_in) & ~chan_mask) == '0);
endmodule

// File: rtl/lch_fanin.sv
module lch_fanin
  import lch_pkg::*;
#(
  parameter int NPHYS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPHYS-1:0]  comb_in,
  input  logic [2:0]        mode,
  output logic [NPHYS/2-1:0] lch_out
);
  localparam int NLOG = NPHYS / 2;
  localparam int NQ   = NPHYS / 4;
  localparam int NO   = NPHYS / 8;

  logic [NLOG-1:0] or2_w, and2_w, or4_w, or8_w, cp2_w, cp4_w;

  for (genvar k = 0; k < NLOG; k++) begin : g_lane
    assign or2_w[k]  = |comb_in[2*k +: 2];
    assign and2_w[k] = pair_hit(comb_in[2*k +: 2]);
    if (k < NQ) begin : g_quad
      assign or4_w[k] = |comb_in[4*k +: 4];
      assign cp2_w[k] = |and2_w[2*k +: 2];
    end else begin : g_quad_off
      assign or4_w[k] = 1'b0;
      assign cp2_w[k] = 1'b0;
    end
    if (k < NO) begin : g_oct
      assign or8_w[k] = |comb_in[8*k +: 8];
      assign cp4_w[k] = |and2_w[4*k +: 4];
    end else begin : g_oct_off
      assign or8_w[k] = 1'b0;
      assign cp4_w[k] = 1'b0;
    end
  end

  always_comb begin
    case (lch_mode_e'(mode))
      M_OR2:   lch_out = or2_w;
      M_OR4:   lch_out = or4_w;
      M_OR8:   lch_out = or8_w;
      M_AND2:  lch_out = and2_w;
      M_CP2:   lch_out = cp2_w;
      M_CP4:   lch_out = cp4_w;
      default: lch_out = '0;
    endcase
  end

  assert_spare_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 3'd6) |-> lch_out == '0);
  assert_and2_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> (lch_out & ~or2_w) == '0);
  assert_or4_upper_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> lch_out[NLOG-1:NQ] == '0);
  assert_cp2_upper_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> lch_out[NLOG-1:NQ] == '0);
  assert_or8_upper_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |-> lch_out[NLOG-1:NO] == '0);
  assert_cp4_within_or8_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd5) |-> (lch_out & ~or8_w) == '0);
  assert_or2_covers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |-> $countones(lch_out) >= $countones(and2_w));
endmodule

// File: rtl/lch_combiner.sv
module lch_combiner #(
  parameter int NPHYS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPHYS-1:0]   phys_in,
  input  logic [NPHYS-1:0]   chan_mask,
  input  logic [2:0]         mode,
  input  logic               pat_sel,
  input  logic [NPHYS-1:0]   pat_reg,
  output logic [NPHYS/2-1:0] lch_out,
  output logic [NPHYS/2-1:0] lch_q
);
  localparam int NLOG = NPHYS / 2;

  logic [NPHYS-1:0] comb_in;

  lch_src_sel #(.NPHYS(NPHYS)) u_src (
    .clk(clk), .rst_n(rst_n), .phys_in(phys_in), .pat_reg(pat_reg),
    .pat_sel(pat_sel), .chan_mask(chan_mask), .comb_in(comb_in)
  );

  lch_fanin #(.NPHYS(NPHYS)) u_fanin (
    .clk(clk), .rst_n(rst_n), .comb_in(comb_in), .mode(mode), .lch_out(lch_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lch_q <= '0;
    else        lch_q <= lch_out;
  end

  assert_reg_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> lch_q == $past(lch_out));
  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |-> lch_q == {NLOG{1'b0}});
endmodule

// File: tb/test_lch_combiner.sv
module test_lch_combiner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] phys_in = '0, chan_mask = '0, pat_reg = '0;
  logic [2:0]  mode = '0;
  logic        pat_sel = 1'b0;
  logic [7:0]  lch_out, lch_q;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] seed = 16'hACE1;

  always #10 clk = ~clk;

  lch_combiner i_lch_combiner (
    .clk(clk), .rst_n(rst_n), .phys_in(phys_in), .chan_mask(chan_mask),
    .mode(mode), .pat_sel(pat_sel), .pat_reg(pat_reg),
    .lch_out(lch_out), .lch_q(lch_q)
  );

  // expected: group width and coincidence flag per mode, computed on integers
  function automatic logic [7:0] model(input int m, input logic [15:0] c);
    int w, andp, nout;
    logic [7:0] r = '0;
    case (m)
      0: begin w = 2; andp = 0; end
      1: begin w = 4; andp = 0; end
      2: begin w = 8; andp = 0; end
      3: begin w = 2; andp = 1; end
      4: begin w = 4; andp = 1; end
      5: begin w = 8; andp = 1; end
      default: begin w = 16; andp = 0; end
    endcase
    nout = (m >= 6) ? 0 : 16 / w;
    for (int k = 0; k < nout; k++) begin
      for (int b = 0; b < w; b++) begin
        if (andp == 0) begin
          if (c[k*w+b]) r[k] = 1'b1;
        end else if (b % 2 == 0) begin
          if (c[k*w+b] && c[k*w+b+1]) r[k] = 1'b1;
        end
      end
    end
    return r;
  endfunction

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R3"; 1: return "R4"; 2: return "R5";
      3: return "R6"; 4: return "R7"; 5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (mode %0d sel %0b phys %h pat %h mask %h)",
               tag, act, exp, mode, pat_sel, phys_in, pat_reg, chan_mask);
    end
  endtask

  task automatic run_vec(input int m, input logic [15:0] ph, input logic [15:0] pt,
                         input logic sel, input logic [15:0] mk, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    mode = m[2:0]; phys_in = ph; pat_reg = pt; pat_sel = sel; chan_mask = mk;
    exp = model(m, (sel ? pt : ph) & ~mk);
    #1 check(tag, lch_out, exp);
    @(posedge clk);
    #1 check("R10", lch_q, exp);
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] s);
    logic [15:0] v = s;
    v ^= v << 7; v ^= v >> 9; v ^= v << 8;
    return v;
  endfunction

  task automatic finish_report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R10", lch_q, 8'h00);  // reset state
    @(negedge clk); rst_n = 1'b1;
    for (int m = 0; m < 8; m++) begin
      run_vec(m, 16'h0000, 16'hFFFF, 1'b0, 16'h0000, mode_tag(m));
      run_vec(m, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, mode_tag(m));
      for (int i = 0; i < 16; i++)
        run_vec(m, 16'h1 << i, ~(16'h1 << i), 1'b0, 16'h0000, mode_tag(m));
      for (int i = 0; i < 15; i++)
        run_vec(m, 16'h3 << i, ~(16'h3 << i), 1'b0, 16'h0000, mode_tag(m));
      for (int i = 0; i < 16; i++)  // pattern source, live inputs complemented
        run_vec(m, ~(16'h3 << i), 16'h3 << i, 1'b1, 16'h0000, "R1");
      for (int i = 0; i < 16; i++)  // mask kills single channels of all-ones
        run_vec(m, 16'hFFFF, 16'h0000, 1'b0, 16'h1 << i, "R2");
      for (int i = 0; i < 60; i++) begin
        logic [15:0] a, mk;
        seed = nxt(seed); a = seed;
        seed = nxt(seed); mk = seed & nxt(seed);
        run_vec(m, a, ~a, i[0], mk, i[0] ? "R1" : "R2");
      end
    end
    // R10: reset mid-run clears the registered copy
    @(negedge clk); mode = 3'd0; pat_sel = 1'b0; chan_mask = '0; phys_in = 16'hFFFF;
    rst_n = 1'b0;
    #1 check("R10", lch_q, 8'h00);
    check("R10", lch_out, 8'hFF);
    finish_report();
  end
endmodule